// File: doc/BRIEF.md
# Multi-Channel Level and Edge Trigger Matcher

This block watches a parallel sample bus and decides, for every accepted sample, whether a trigger condition configured by software holds. Four mask words, each one bit per channel, configure it: which channels are active, which of those take part in the trigger, whether each participating channel tests a steady level or a transition, and a polarity bit whose meaning depends on that choice. The trigger fires only when every participating channel meets its condition on the same sample.

Samples arrive on a valid/ready stream. The matcher never applies back-pressure: ready is held high, so every cycle with valid high is a transfer, and the producer need not wait. Edge tests compare the transfer with the one before it. An arm pulse clears that history, so the first transfer after arming (or reset) never counts as an edge. The hit output and the error flag are plain control pins.

Top module: `trig_match`

## Requirements
- R1: After reset, `hit` is low.
- R2: `samp_ready` is high in every cycle; each cycle with `samp_valid` high is one accepted sample.
- R3: A participating channel whose level-select bit is 1 is met when its sample bit equals its polarity bit (1 = high, 0 = low). `hit` reflects an accepted sample in the cycle after the transfer.
- R4: A participating channel whose level-select bit is 0 is an edge test against the previous accepted sample: polarity 0 needs a 0-to-1 change, polarity 1 needs a 1-to-0 change.
- R5: `hit` rises only when all participating channels are met on the same sample.
- R6: A channel takes part only when both its active bit and its trigger-enable bit are 1; any other channel has no effect on `hit`.
- R7: When no channel takes part, `hit` stays low for every sample.
- R8: `cfg_err` is high, in the same cycle as the configuration, whenever more than one participating channel is an edge test; while it is high no sample raises `hit`.
- R9: The first sample accepted after reset, or in or after a cycle with `arm` high, meets no edge test; it becomes the history for the next one.
- R10: `hit` is a one-cycle pulse: it is low in the cycle after any cycle with no accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Clears the edge history |
| cfg_chan | input | W | Active-channel mask |
| cfg_en | input | W | Trigger-participation mask |
| cfg_lvl | input | W | 1 = level test, 0 = edge test |
| cfg_pol | input | W | Level: 1 high / 0 low; edge: 1 falling / 0 rising |
| samp_valid | input | 1 | Sample stream valid |
| samp_ready | output | 1 | Sample stream ready (always 1) |
| samp_data | input | W | Sample word, one bit per channel |
| hit | output | 1 | Trigger condition met by the previous accepted sample |
| cfg_err | output | 1 | More than one edge channel configured |

## Verification
On every cycle the assertions check that ready never drops, that `hit` cannot follow an idle cycle, a configuration with no participating channel, or an erroneous configuration, and that a pure-level configuration matched by the sample always raises `hit`. Edge behaviour, the history cleared by arming, the effect of the active mask and the exact error decoding depend on sequences of samples and are shown only by the bench, which sweeps every enable, level and polarity combination of a four-channel instance against sample pairs derived from the configuration.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Condition for one channel: level test or edge test against history.
  function automatic logic chan_cond(input logic lvl, input logic pol,
                                     input logic cur, input logic prv,
                                     input logic has_prev);
    if (lvl) return cur == pol;
    if (!has_prev) return 1'b0;
    return pol ? (prv && !cur) : (!prv && cur);
  endfunction

endpackage

// File: rtl/trig_hist.sv
module trig_hist #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         take,
  input  logic [W-1:0] data,
  output logic [W-1:0] prev,
  output logic         has_prev
);
  logic hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= '0;
      hist_q <= 1'b0;
    end else if (take) begin
      prev   <= data;
      hist_q <= 1'b1;
    end else if (arm) begin
      hist_q <= 1'b0;
    end
  end

  // An arm in the same cycle as a sample discards the stored history.
  assign has_prev = hist_q && !arm;
endmodule

// File: rtl/trig_lanes.sv
module trig_lanes #(
  parameter int W = 16
) (
  input  logic [W-1:0] part,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prv,
  input  logic         has_prev,
  output logic [W-1:0] ok
);
  import trig_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign ok[i] = !part[i] ||
                   chan_cond(lvl[i], pol[i], cur[i], prv[i], has_prev);
  end
endmodule

// File: rtl/trig_reduce.sv
module trig_reduce #(
  parameter int W = 16
) (
  input  logic [W-1:0] ok,
  input  logic [W-1:0] part,
  input  logic [W-1:0] lvl,
  output logic         match,
  output logic         err
);
  logic [W-1:0] edge_chans;

  assign edge_chans = part & ~lvl;
  assign err        = $countones(edge_chans) > 1;
  assign match      = (|part) && (&ok) && !err;
endmodule

// File: rtl/trig_match.sv
module trig_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] cfg_chan,
  input  logic [W-1:0] cfg_en,
  input  logic [W-1:0] cfg_lvl,
  input  logic [W-1:0] cfg_pol,
  input  logic         samp_valid,
  output logic         samp_ready,
  input  logic [W-1:0] samp_data,
  output logic         hit,
  output logic         cfg_err
);
  logic         take;
  logic [W-1:0] part;
  logic [W-1:0] prev;
  logic         has_prev;
  logic [W-1:0] ok;
  logic         match;

  assign samp_ready = 1'b1;
  assign take       = samp_valid && samp_ready;
  assign part       = cfg_chan & cfg_en;

  trig_hist #(.W(W)) u_hist (
    .clk(clk), .rst_n(rst_n), .arm(arm), .take(take),
    .data(samp_data), .prev(prev), .has_prev(has_prev)
  );

  trig_lanes #(.W(W)) u_lanes (
    .part(part), .lvl(cfg_lvl), .pol(cfg_pol), .cur(samp_data),
    .prv(prev), .has_prev(has_prev), .ok(ok)
  );

  trig_reduce #(.W(W)) u_reduce (
    .ok(ok), .part(part), .lvl(cfg_lvl), .match(match), .err(cfg_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= take && match;
  end
endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cfg_chan,
  input logic [W-1:0] cfg_en,
  input logic [W-1:0] cfg_lvl,
  input logic [W-1:0] cfg_pol,
  input logic         samp_valid,
  input logic         samp_ready,
  input logic [W-1:0] samp_data,
  input logic         hit,
  input logic         cfg_err
);
  logic [W-1:0] part;
  assign part = cfg_chan & cfg_en;

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    samp_ready);

  p_idle_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |=> !hit);

  p_none_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && part == '0) |=> !hit);

  p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && cfg_err) |=> !hit);

  p_level_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && part != '0 && (part & ~cfg_lvl) == '0 &&
     ((samp_data ^ cfg_pol) & part) == '0) |=> hit);
endmodule

bind trig_match trig_match_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_en(cfg_en),
  .cfg_lvl(cfg_lvl), .cfg_pol(cfg_pol), .samp_valid(samp_valid),
  .samp_ready(samp_ready), .samp_data(samp_data), .hit(hit),
  .cfg_err(cfg_err)
);

// File: tb/trig_match_tb.sv
module trig_match_tb;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arm = 1'b0;
  logic [W-1:0] cfg_chan = '1, cfg_en = '0, cfg_lvl = '0, cfg_pol = '0;
  logic         samp_valid = 1'b0;
  logic         samp_ready;
  logic [W-1:0] samp_data = '0;
  logic         hit, cfg_err;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_match #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_chan(cfg_chan),
    .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .cfg_pol(cfg_pol),
    .samp_valid(samp_valid), .samp_ready(samp_ready),
    .samp_data(samp_data), .hit(hit), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (chan=%h en=%h lvl=%h pol=%h)",
               req, act, exp, cfg_chan, cfg_en, cfg_lvl, cfg_pol);
    end
  endtask

  // Reference model written from the requirements.
  function automatic logic model(input logic [W-1:0] ch, en, lv, po, p, c,
                                 input logic hp);
    logic [W-1:0] pt;
    int edges;
    logic res;
    pt = ch & en;
    if (pt == '0) return 1'b0;
    edges = 0;
    for (int i = 0; i < W; i++) if (pt[i] && !lv[i]) edges++;
    if (edges > 1) return 1'b0;
    res = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (pt[i]) begin
        if (lv[i]) begin
          if (c[i] != po[i]) res = 1'b0;
        end else begin
          if (!hp) res = 1'b0;
          else if (po[i] && !(p[i] && !c[i])) res = 1'b0;
          else if (!po[i] && !(!p[i] && c[i])) res = 1'b0;
        end
      end
    end
    return res;
  endfunction

  function automatic logic model_err(input logic [W-1:0] ch, en, lv);
    logic [W-1:0] e;
    e = ch & en & ~lv;
    return $countones(e) > 1;
  endfunction

  // Drive one sample at a falling edge; returns hit seen one cycle later.
  task automatic send(input logic [W-1:0] d, output logic h);
    @(negedge clk);
    samp_valid = 1'b1;
    samp_data  = d;
    @(negedge clk);
    samp_valid = 1'b0;
    h = hit;
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic h;
    logic [W-1:0] p, c;
    repeat (3) @(negedge clk);
    check("R1 reset hit", hit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hit after reset", hit, 1'b0);
    check("R2 ready", samp_ready, 1'b1);

    // R3 R4 R5 R8 R9: sweep every enable/level/polarity combination.
    for (int k = 0; k < (1 << (3*W)); k++) begin
      cfg_chan = '1;
      cfg_en   = k[W-1:0];
      cfg_lvl  = k[2*W-1:W];
      cfg_pol  = k[3*W-1:2*W];
      #1;
      check("R8 cfg_err", cfg_err, model_err(cfg_chan, cfg_en, cfg_lvl));
      for (int j = 0; j < 2; j++) begin
        p = W'((k * 7 + j * 5) & ((1 << W) - 1));
        c = (j == 0) ? (p ^ cfg_en) : W'((k * 3 + 9) & ((1 << W) - 1));
        do_arm();
        send(p, h);
        check("R9 first sample after arm", h,
              model(cfg_chan, cfg_en, cfg_lvl, cfg_pol, '0, p, 1'b0));
        send(c, h);
        check("R3 R4 R5 second sample", h,
              model(cfg_chan, cfg_en, cfg_lvl, cfg_pol, p, c, 1'b1));
      end
    end

    // R6: inactive channels ignored even with mismatching data.
    for (int m = 0; m < (1 << W); m++) begin
      cfg_chan = W'(m);
      cfg_en   = '1;
      cfg_lvl  = '1;
      cfg_pol  = '1;
      send(W'(m), h);
      check("R6 active mask", h, (m != 0));
      // R10: idle cycle after a sample leaves hit low.
      @(negedge clk);
      check("R10 idle pulse end", hit, 1'b0);
    end

    // R7: no participating channel never hits.
    cfg_chan = '1; cfg_en = '0; cfg_lvl = '1; cfg_pol = '0;
    send('0, h);
    check("R7 none enabled", h, 1'b0);

    // R9: arm in the same cycle as a sample discards history.
    cfg_en = 4'b0001; cfg_lvl = '0; cfg_pol = '0;
    send(4'b0000, h);
    @(negedge clk);
    arm = 1'b1; samp_valid = 1'b1; samp_data = 4'b0001;
    @(negedge clk);
    arm = 1'b0; samp_valid = 1'b0;
    check("R9 arm with sample", hit, 1'b0);
    send(4'b0000, h);
    send(4'b0001, h);
    check("R4 rising after history", h, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule